// File: doc/BRIEF.md
# Peripheral Reset and Clock-Enable Controller

This block is a register-mapped controller that drives a per-peripheral reset and a per-peripheral clock enable for a parameterised set of on-chip devices. Software reaches it over a plain 32-bit register bus. Each device owns one word slot in a reset bank and one word slot at the same relative offset in a clock-gate bank. The slot keeps only the bits that the device's mask implements. After power-on every device is held in reset with its clock stopped. Software releases a device by clearing its reset bits and starting its clock, normally through read-modify-write sequences.

A status region at the bottom of the map holds per-device disable bits. There is one bit per device, packed from the most significant bit downwards. A device that is disabled is forced into full reset with its clock enable low, whatever its own words hold. The first two status words read back as fixed identification words: a silicon revision and a defect-status word. Reset and clock-enable outputs are registered, so clock-gating cells downstream see clean enables.

Top module: `periph_rstclk_ctrl`

## Requirements
- R1: Device i has its reset word at byte address 0x1000 + 4*i and its clock-gate word at 0x2000 + 4*i, for i below NUM_DEV. A registered read returns the stored bits in positions [3:0], and the upper bits read as zero.
- R2: A slot stores only the bits of its mask, and the other bits are dropped on write and read as zero. Device 0 uses reset mask 0x7 and gate mask 0xF. Device 1 uses 0xA for both. Every other device uses 0x1 for both.
- R3: While rst_n is low on a clock edge, each reset word loads its full mask and each gate word and each disable bit clears to zero. The outputs then show every device in full reset with its clock enable low.
- R4: Device i drives its reset output on bits dev_rst_o[4*i+3:4*i], and a 1 holds that part in reset. Writing 0 to a bit of the reset word releases that part.
- R5: Device i drives its clock-enable output on bits dev_clk_en_o[4*i+3:4*i], which follow the gate word. Both outputs are registered: a write sampled on edge k changes the outputs on edge k+1, not before.
- R6: The disable bit of device i is bit 31-4*(i%8) of the status word at byte address 4*(i/8). A write stores every implemented disable bit of that word, so a 0 clears the bit again.
- R7: While device i is disabled, its reset output equals its full reset mask and its clock enable is zero, one edge after the disable bit changes. Its stored reset and gate words are unchanged and read back as written.
- R8: Address 0x0 reads as REVISION and address 0x4 reads as DEFECT_STATUS, where bit 1 of DEFECT_STATUS flags a defective L2 cache. Writes to these addresses never change what they read.
- R9: Reads of unmapped or misaligned addresses return 0. Writes to them change no stored word and no output. No error is signalled.
- R10: bus_rdata is loaded on the clock edge that samples bus_rd_en high and holds its value while bus_rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 14 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd_en | input | 1 | Read strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Registered read data |
| dev_rst_o | output | 4*NUM_DEV | Per-device reset lines, 4 per device, 1 means in reset |
| dev_clk_en_o | output | 4*NUM_DEV | Per-device clock enables, 4 per device |

## Verification
The bench builds the block with NUM_DEV = 12, a non-trivial REVISION word, and DEFECT_STATUS = 0x2. With twelve devices the disable bits span two status words: the first word is full and the second holds only four bits. Both words sit under the read-only identification words, so a write there has to change outputs without changing what reads back. The setting also covers both special mask shapes (devices 0 and 1), several single-bit devices, and the first unmapped slot just past the last device.

// File: rtl/prc_pkg.sv
`timescale 1ns/1ps
// Package prc_pkg
// Shared widths, the address-region encoding and the per-device mask
// functions of the reset/clock-enable controller.
// Assumes device slots are 4 bytes apart, so eight devices share one
// 32-bit disable word.
package prc_pkg;
    localparam int ADDR_W      = 14;
    localparam int DATA_W      = 32;
    localparam int SLOT_W      = 4;
    localparam int WORD_W      = ADDR_W - 4;
    localparam int STRIDE_B    = 4;
    localparam int DEV_PER_DIS = DATA_W / STRIDE_B;

    typedef enum logic [1:0] {
        REG_STAT = 2'd0,
        REG_RST  = 2'd1,
        REG_GATE = 2'd2,
        REG_NONE = 2'd3
    } region_e;

    // Implemented reset bits of device idx.
    function automatic logic [SLOT_W-1:0] rst_mask_f(input int idx);
        if (idx == 0)      return 4'h7;
        else if (idx == 1) return 4'hA;
        else               return 4'h1;
    endfunction

    // Implemented clock-gate bits of device idx.
    function automatic logic [SLOT_W-1:0] gate_mask_f(input int idx);
        if (idx == 0)      return 4'hF;
        else if (idx == 1) return 4'hA;
        else               return 4'h1;
    endfunction

    // Status word index that carries the disable bit of device idx.
    function automatic int dis_word_f(input int idx);
        return (idx * STRIDE_B) / DATA_W;
    endfunction

    // Bit position of the disable bit of device idx, counted from the MSB.
    function automatic int dis_bit_f(input int idx);
        return DATA_W - 1 - ((idx * STRIDE_B) % DATA_W);
    endfunction
endpackage

// File: rtl/prc_decode.sv
`timescale 1ns/1ps
// Module prc_decode
// Splits a bus address into region and word index, flags whether the
// address is mapped, and raises one write strobe per stored word.
// Assumes aligned word accesses; a misaligned address is unmapped.
module prc_decode
    import prc_pkg::*;
#(
    parameter int NUM_DEV   = 12,
    parameter int DIS_WORDS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output region_e           region,
    output logic [WORD_W-1:0] word,
    output logic              hit,
    output logic [NUM_DEV-1:0]   rst_we,
    output logic [NUM_DEV-1:0]   gate_we,
    output logic [DIS_WORDS-1:0] dis_we
);
    localparam int STAT_WORDS = (DIS_WORDS > 2) ? DIS_WORDS : 2;

    logic aligned;

    // Field extraction and mapped-address check.
    always_comb begin
        region  = region_e'(addr[ADDR_W-1:ADDR_W-2]);
        word    = addr[ADDR_W-3:2];
        aligned = (addr[1:0] == 2'b00);
        case (region)
            REG_STAT: hit = aligned && (int'(word) < STAT_WORDS);
            REG_RST,
            REG_GATE: hit = aligned && (int'(word) < NUM_DEV);
            default:  hit = 1'b0;
        endcase
    end

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev_we
        assign rst_we[i]  = wr_en && hit && (region == REG_RST)  && (int'(word) == i);
        assign gate_we[i] = wr_en && hit && (region == REG_GATE) && (int'(word) == i);
    end

    for (genvar w = 0; w < DIS_WORDS; w++) begin : g_dis_we
        assign dis_we[w] = wr_en && hit && (region == REG_STAT) && (int'(word) == w);
    end

    // R1: at most one stored word is written per access.
    p_onehot_we_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_we, gate_we, dis_we}));

    // R9: an unmapped write raises no strobe.
    p_unmapped_no_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |-> ({rst_we, gate_we, dis_we} == '0));
endmodule

// File: rtl/prc_disable_bank.sv
`timescale 1ns/1ps
// Module prc_disable_bank
// Holds one disable flag per device. A write to status word w stores
// the bits of the devices that map onto that word; all other bits of
// the write data are dropped.
// Assumes the decoder raises at most one word strobe per cycle.
module prc_disable_bank
    import prc_pkg::*;
#(
    parameter int NUM_DEV   = 12,
    parameter int DIS_WORDS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIS_WORDS-1:0] we,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_DEV-1:0] dev_dis_o
);
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_bit
        localparam int W = dis_word_f(i);
        localparam int B = dis_bit_f(i);

        // Store the device's disable flag from its word and bit position.
        always_ff @(posedge clk) begin
            if (!rst_n)     dev_dis_o[i] <= 1'b0;
            else if (we[W]) dev_dis_o[i] <= wdata[B];
        end

        // R6: the flag only moves on a write to its own word.
        p_dis_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !we[W] |=> $stable(dev_dis_o[i]));
    end
endmodule

// File: rtl/prc_slot.sv
`timescale 1ns/1ps
// Module prc_slot
// Reset and clock-gate words of one device, plus the registered output
// stage that applies the disable override.
// Assumes wdata already holds the low bits of the bus word.
module prc_slot
    import prc_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_we,
    input  logic              gate_we,
    input  logic [SLOT_W-1:0] wdata,
    input  logic              dis_i,
    output logic [SLOT_W-1:0] rst_word_o,
    output logic [SLOT_W-1:0] gate_word_o,
    output logic [SLOT_W-1:0] dev_rst_o,
    output logic [SLOT_W-1:0] dev_clk_en_o
);
    localparam logic [SLOT_W-1:0] RST_M  = rst_mask_f(IDX);
    localparam logic [SLOT_W-1:0] GATE_M = gate_mask_f(IDX);

    // Software-visible words, masked to the implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_word_o  <= RST_M;
            gate_word_o <= '0;
        end else begin
            if (rst_we)  rst_word_o  <= wdata & RST_M;
            if (gate_we) gate_word_o <= wdata & GATE_M;
        end
    end

    // Registered outputs; a disabled device is held in reset, clock off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_rst_o    <= RST_M;
            dev_clk_en_o <= '0;
        end else if (dis_i) begin
            dev_rst_o    <= RST_M;
            dev_clk_en_o <= '0;
        end else begin
            dev_rst_o    <= rst_word_o;
            dev_clk_en_o <= gate_word_o;
        end
    end

    // R3: reset loads full reset mask and a stopped clock.
    p_reset_default_r3: assert property (@(posedge clk)
        !rst_n |=> (rst_word_o == RST_M) && (gate_word_o == '0) && (dev_clk_en_o == '0));

    // R2: unimplemented bits never hold a 1.
    p_mask_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rst_word_o & ~RST_M) == '0) && ((gate_word_o & ~GATE_M) == '0));

    // R7: a disabled device is forced into reset with its clock off.
    p_dis_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |=> (dev_rst_o == RST_M) && (dev_clk_en_o == '0));

    // R5: enables follow the gate word one edge later.
    p_clk_registered_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dis_i |=> dev_clk_en_o == $past(gate_word_o));
endmodule

// File: rtl/periph_rstclk_ctrl.sv
`timescale 1ns/1ps
// Module periph_rstclk_ctrl
// Register-mapped reset and clock-enable controller for NUM_DEV
// peripherals. Region 0 holds disable flags under two read-only
// identification words, region 1 the reset words, region 2 the gate
// words. Read data is registered.
// Assumes one access per cycle; simultaneous read and write is legal
// and the read returns the value before the write.
module periph_rstclk_ctrl
    import prc_pkg::*;
#(
    parameter int          NUM_DEV       = 12,
    parameter logic [31:0] REVISION      = 32'h0001_0A37,
    parameter logic [31:0] DEFECT_STATUS = 32'h0000_0002
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic                      bus_wr_en,
    input  logic                      bus_rd_en,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [NUM_DEV*SLOT_W-1:0] dev_rst_o,
    output logic [NUM_DEV*SLOT_W-1:0] dev_clk_en_o
);
    localparam int DIS_WORDS = (NUM_DEV + DEV_PER_DIS - 1) / DEV_PER_DIS;

    region_e                          region;
    logic [WORD_W-1:0]                word;
    logic                             hit;
    logic [NUM_DEV-1:0]               rst_we;
    logic [NUM_DEV-1:0]               gate_we;
    logic [DIS_WORDS-1:0]             dis_we;
    logic [NUM_DEV-1:0]               dev_dis;
    logic [NUM_DEV-1:0][SLOT_W-1:0]   rst_words;
    logic [NUM_DEV-1:0][SLOT_W-1:0]   gate_words;
    logic [DATA_W-1:0]                rd_val;

    prc_decode #(
        .NUM_DEV  (NUM_DEV),
        .DIS_WORDS(DIS_WORDS)
    ) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wr_en  (bus_wr_en),
        .region (region),
        .word   (word),
        .hit    (hit),
        .rst_we (rst_we),
        .gate_we(gate_we),
        .dis_we (dis_we)
    );

    prc_disable_bank #(
        .NUM_DEV  (NUM_DEV),
        .DIS_WORDS(DIS_WORDS)
    ) u_dis (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (dis_we),
        .wdata    (bus_wdata),
        .dev_dis_o(dev_dis)
    );

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_slot
        prc_slot #(.IDX(i)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .rst_we      (rst_we[i]),
            .gate_we     (gate_we[i]),
            .wdata       (bus_wdata[SLOT_W-1:0]),
            .dis_i       (dev_dis[i]),
            .rst_word_o  (rst_words[i]),
            .gate_word_o (gate_words[i]),
            .dev_rst_o   (dev_rst_o[i*SLOT_W +: SLOT_W]),
            .dev_clk_en_o(dev_clk_en_o[i*SLOT_W +: SLOT_W])
        );
    end

    // Read multiplexer over identification words and device slots.
    always_comb begin
        rd_val = '0;
        if (hit) begin
            case (region)
                REG_STAT: begin
                    if (int'(word) == 0)      rd_val = REVISION;
                    else if (int'(word) == 1) rd_val = DEFECT_STATUS;
                end
                REG_RST: begin
                    for (int i = 0; i < NUM_DEV; i++)
                        if (int'(word) == i) rd_val = DATA_W'(rst_words[i]);
                end
                REG_GATE: begin
                    for (int i = 0; i < NUM_DEV; i++)
                        if (int'(word) == i) rd_val = DATA_W'(gate_words[i]);
                end
                default: rd_val = '0;
            endcase
        end
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= rd_val;
    end

    // R9: unmapped reads return zero.
    p_unmapped_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && !hit) |=> bus_rdata == '0);

    // R8: the revision word is constant.
    p_revision_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == '0) |=> bus_rdata == REVISION);

    // R10: read data holds without a strobe.
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rdata));
endmodule

// File: tb/sim_periph_rstclk_ctrl.sv
`timescale 1ns/1ps
module sim_periph_rstclk_ctrl;
    localparam int          ND   = 12;
    localparam logic [31:0] REV  = 32'h0001_0A37;
    localparam logic [31:0] DEF  = 32'h0000_0002;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [13:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_wr_en = 1'b0;
    logic          bus_rd_en = 1'b0;
    logic [31:0]   bus_rdata;
    logic [ND*4-1:0] dev_rst_o;
    logic [ND*4-1:0] dev_clk_en_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [3:0] m_rst  [ND];
    logic [3:0] m_gate [ND];
    logic       m_dis  [ND];

    always #4 clk = ~clk;

    periph_rstclk_ctrl #(.NUM_DEV(ND), .REVISION(REV), .DEFECT_STATUS(DEF)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
        .dev_rst_o(dev_rst_o), .dev_clk_en_o(dev_clk_en_o)
    );

    function automatic logic [3:0] rmask(int i);
        return (i == 0) ? 4'h7 : (i == 1) ? 4'hA : 4'h1;
    endfunction
    function automatic logic [3:0] gmask(int i);
        return (i == 0) ? 4'hF : (i == 1) ? 4'hA : 4'h1;
    endfunction
    function automatic logic [ND*4-1:0] exp_rst_vec();
        logic [ND*4-1:0] v;
        for (int i = 0; i < ND; i++) v[i*4 +: 4] = m_dis[i] ? rmask(i) : m_rst[i];
        return v;
    endfunction
    function automatic logic [ND*4-1:0] exp_clk_vec();
        logic [ND*4-1:0] v;
        for (int i = 0; i < ND; i++) v[i*4 +: 4] = m_dis[i] ? 4'h0 : m_gate[i];
        return v;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [13:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        // model update
        if (a[1:0] == 2'b00) begin
            if (a[13:12] == 2'd1 && int'(a[11:2]) < ND) m_rst[a[11:2]] = d[3:0] & rmask(int'(a[11:2]));
            if (a[13:12] == 2'd2 && int'(a[11:2]) < ND) m_gate[a[11:2]] = d[3:0] & gmask(int'(a[11:2]));
            if (a[13:12] == 2'd0)
                for (int i = 0; i < ND; i++)
                    if (int'(a[11:2]) == i / 8) m_dis[i] = d[31 - 4 * (i % 8)];
        end
    endtask

    task automatic bus_read(logic [13:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle_and_check_outputs(string req);
        @(negedge clk);
        @(negedge clk);
        check(req, 64'(dev_rst_o), 64'(exp_rst_vec()));
        check(req, 64'(dev_clk_en_o), 64'(exp_clk_vec()));
    endtask

    task automatic readback_all(string req);
        logic [31:0] d;
        for (int i = 0; i < ND; i++) begin
            bus_read(14'h1000 + 14'(4 * i), d);
            check(req, 64'(d), 64'(m_rst[i]));
            bus_read(14'h2000 + 14'(4 * i), d);
            check(req, 64'(d), 64'(m_gate[i]));
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] held;
        void'($urandom(32'd2024));
        for (int i = 0; i < ND; i++) begin
            m_rst[i] = rmask(i); m_gate[i] = 4'h0; m_dis[i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset defaults on outputs and words
        check("R3", 64'(dev_rst_o), 64'(exp_rst_vec()));
        check("R3", 64'(dev_clk_en_o), 64'h0);
        readback_all("R3");

        // R2: mask effect on full-ones writes
        bus_write(14'h1000, 32'hFFFF_FFFF);
        bus_write(14'h2000, 32'hFFFF_FFFF);
        bus_write(14'h1004, 32'hFFFF_FFFF);
        bus_write(14'h2004, 32'h0000_0005);
        bus_write(14'h1008, 32'hFFFF_FFFE);
        bus_read(14'h1000, d); check("R2", 64'(d), 64'h7);
        bus_read(14'h2000, d); check("R2", 64'(d), 64'hF);
        bus_read(14'h1004, d); check("R2", 64'(d), 64'hA);
        bus_read(14'h2004, d); check("R2", 64'(d), 64'h0);
        bus_read(14'h1008, d); check("R2", 64'(d), 64'h0);

        // R4/R1: set then clear bits by read-modify-write
        bus_read(14'h1000 + 14'(4 * 5), d);
        bus_write(14'h1000 + 14'(4 * 5), d & ~32'h1);
        settle_and_check_outputs("R4");
        bus_read(14'h1000 + 14'(4 * 5), d); check("R1", 64'(d), 64'h0);
        bus_write(14'h1000 + 14'(4 * 5), d | 32'h1);
        settle_and_check_outputs("R4");

        // R5: enable changes one edge after the write edge
        held = 32'(dev_clk_en_o[3*4 +: 4]);
        bus_write(14'h2000 + 14'(4 * 3), 32'h1);
        check("R5", 64'(dev_clk_en_o[3*4 +: 4]), 64'(held));
        @(negedge clk);
        check("R5", 64'(dev_clk_en_o[3*4 +: 4]), 64'h1);

        // R6/R7: disable device 3 (word 0, bit 19) and device 9 (word 1, bit 27)
        bus_write(14'h2000 + 14'(4 * 9), 32'h1);
        bus_write(14'h1000 + 14'(4 * 9), 32'h0);
        bus_write(14'h0000, 32'h1 << 19);
        bus_write(14'h0004, 32'h1 << 27);
        settle_and_check_outputs("R7");
        check("R7", 64'(dev_clk_en_o[3*4 +: 4]), 64'h0);
        check("R6", 64'(dev_rst_o[9*4 +: 4]), 64'h1);
        bus_read(14'h2000 + 14'(4 * 3), d); check("R7", 64'(d), 64'h1);
        bus_read(14'h1000 + 14'(4 * 9), d); check("R7", 64'(d), 64'h0);
        // R8: identification words unchanged after those writes
        bus_read(14'h0000, d); check("R8", 64'(d), 64'(REV));
        bus_read(14'h0004, d); check("R8", 64'(d), 64'(DEF));
        // R6: writing 0 re-enables
        bus_write(14'h0000, 32'h0);
        bus_write(14'h0004, 32'h0);
        settle_and_check_outputs("R6");
        check("R6", 64'(dev_clk_en_o[9*4 +: 4]), 64'h1);

        // R9: unmapped and misaligned accesses
        bus_write(14'h1000 + 14'(4 * ND), 32'hFFFF_FFFF);
        bus_write(14'h3000, 32'hFFFF_FFFF);
        bus_write(14'h2001 + 14'(4 * 4), 32'hFFFF_FFFF);
        bus_write(14'h0008, 32'hFFFF_FFFF);
        settle_and_check_outputs("R9");
        bus_read(14'h1000 + 14'(4 * ND), d); check("R9", 64'(d), 64'h0);
        bus_read(14'h3000, d);               check("R9", 64'(d), 64'h0);
        bus_read(14'h0008, d);               check("R9", 64'(d), 64'h0);
        bus_read(14'h2001, d);               check("R9", 64'(d), 64'h0);
        readback_all("R9");

        // R10: rdata holds without a read strobe
        bus_read(14'h0000, d);
        bus_write(14'h1000, 32'h0);
        repeat (3) @(negedge clk);
        check("R10", 64'(bus_rdata), 64'(REV));

        // Random mix of writes, disables and reads
        for (int n = 0; n < 400; n++) begin
            int op  = int'($urandom % 8);
            int dev = int'($urandom % ND);
            logic [31:0] v = $urandom;
            if (op < 3)       bus_write(14'h1000 + 14'(4 * dev), v);
            else if (op < 6)  bus_write(14'h2000 + 14'(4 * dev), v);
            else if (op == 6) bus_write(14'(4 * ($urandom % 2)), v & $urandom & $urandom);
            else begin
                bus_read(14'h1000 + 14'(4 * dev), d); check("R1", 64'(d), 64'(m_rst[dev]));
                bus_read(14'h2000 + 14'(4 * dev), d); check("R1", 64'(d), 64'(m_gate[dev]));
            end
            settle_and_check_outputs("R7");
        end
        readback_all("R2");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule